// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the execution unit of a small 16-bit processor and takes over at instruction boundaries. When the core reports that an instruction has completed, the sequencer decides whether a pending request should be serviced. A non-maskable request is honoured while the X mask is clear. A maskable request is honoured only while the I mask is clear. When a request is taken, the sequencer does the following in order:
- it pulses a queue-flush strobe;
- it captures the return address and the register file;
- it writes a nine-byte frame below the stack pointer, one byte per handshake;
- it raises the mask bits once the condition-code byte has been stored;
- it reads the 16-bit vector of the source that won at the start.

A return command runs the frame in the opposite direction. The sequencer reads the nine bytes upward from the stack pointer and rebuilds every register. Both sequences end with a single-cycle load strobe. On that strobe the core copies the presented program counter, stack pointer, index registers, accumulators and condition codes into its register file. The core holds off issuing instructions while the busy output is high.

Top module: `intr_stack_seq`

## Requirements
- R1: At a cycle with `insn_done` high and `rti_cmd` low, a non-maskable request is accepted only if `ccr_in` bit 6 (X) is 0. A maskable request is accepted only if `ccr_in` bit 4 (I) is 0. With neither condition met, no write, read or flush occurs and `busy` stays low.
- R2: A non-maskable request outranks all maskable lines. Among the maskable lines, lower index wins. The vector is read from address `VEC_TOP` for the non-maskable source and from `VEC_TOP - 2*(i+1)` for maskable line i.
- R3: `flush` is high for exactly one cycle, the cycle right after acceptance, and the first stack write is offered in the following cycle. The return address is the `pc_in` value sampled at acceptance.
- R4: Entry issues exactly nine byte writes at descending addresses SP-1 down to SP-9. The bytes are, in that order: return address low, return address high, Y low, Y high, X low, X high, A, B, condition codes. No two of the write, stack-read and vector-read requests are active together.
- R5: While a write is offered and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold unchanged.
- R6: `ccr_out` equals the captured `ccr_in` up to and including the cycle of the ninth write. From the next cycle on, bit 4 is set, and bit 6 is also set when the serviced source is non-maskable.
- R7: The serviced source is fixed at acceptance. Request changes after that do not alter the vector address or the X update.
- R8: After entry, the `reg_load` cycle presents `pc_out` equal to the fetched vector data and `sp_out` equal to SP-9.
- R9: A return reads addresses SP through SP+8 in ascending order, with no flush and no writes. It rebuilds condition codes, B, A, X (high then low), Y (high then low) and the return address (high then low) from those bytes. It presents `sp_out` = SP+9 on `reg_load`.
- R10: After reset, all request outputs, `flush`, `busy` and `reg_load` are low. `busy` is high from the cycle after acceptance through the `reg_load` cycle and low in the cycle after.
- R11: When `rti_cmd` and `insn_done` are both high with a request pending, the return sequence runs and no entry is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Instruction boundary: requests are evaluated |
| rti_cmd | input | 1 | Start the return-from-interrupt sequence |
| irq_req | input | N_SRC | Maskable request lines, index 0 highest |
| nmi_req | input | 1 | Non-maskable request |
| pc_in | input | 16 | Return address offered by the core |
| sp_in | input | 16 | Current stack pointer |
| x_in | input | 16 | X index register |
| y_in | input | 16 | Y index register |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| ccr_in | input | 8 | Condition codes (bit 6 X mask, bit 4 I mask) |
| flush | output | 1 | Instruction queue flush strobe |
| busy | output | 1 | Sequence in progress |
| wr_valid | output | 1 | Stack byte write request |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write byte |
| rd_valid | output | 1 | Stack byte read request |
| rd_ready | input | 1 | Read data valid this cycle |
| rd_addr | output | 16 | Read address |
| rd_data | input | 8 | Read byte |
| vec_valid | output | 1 | Vector read request |
| vec_ready | input | 1 | Vector data valid this cycle |
| vec_addr | output | 16 | Vector slot address |
| vec_data | input | 16 | Vector contents |
| reg_load | output | 1 | Register file load strobe |
| pc_out | output | 16 | Program counter to load |
| sp_out | output | 16 | Stack pointer to load |
| x_out | output | 16 | X to load |
| y_out | output | 16 | Y to load |
| a_out | output | 8 | A to load |
| b_out | output | 8 | B to load |
| ccr_out | output | 8 | Condition codes to load |
| svc_nmi | output | 1 | Serviced source is non-maskable |
| svc_src | output | SRC_W | Index of serviced maskable line |

## Verification
On entry, `flush` appears one cycle after the accepting edge and the first write one cycle after that. Each further byte takes one cycle plus any cycles with ready low. The mask update shows one cycle after the ninth write handshake, the vector request follows, and `reg_load` comes one cycle after the vector handshake. A return presents nine reads and then `reg_load` one cycle after the last read handshake. Because ready stalls are random, the bench does not count fixed delays. It logs every handshake at the rising edge, checks outputs at the falling edge in which `reg_load` is seen, and checks `busy` one falling edge later.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  localparam int FRAME_BYTES = 9;
  localparam int CCR_I_BIT   = 4;
  localparam int CCR_X_BIT   = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CAPT, ST_PUSH, ST_VEC, ST_POP, ST_LOAD
  } seq_state_t;

  typedef struct packed {
    logic [15:0] pc;
    logic [15:0] y;
    logic [15:0] x;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  ccr;
  } cpu_frame_t;

  // byte written at depth (idx+1) below the entry stack pointer
  function automatic logic [7:0] push_byte(input cpu_frame_t f, input logic [3:0] idx);
    case (idx)
      4'd0:    return f.pc[7:0];
      4'd1:    return f.pc[15:8];
      4'd2:    return f.y[7:0];
      4'd3:    return f.y[15:8];
      4'd4:    return f.x[7:0];
      4'd5:    return f.x[15:8];
      4'd6:    return f.a;
      4'd7:    return f.b;
      default: return f.ccr;
    endcase
  endfunction

  // merge a byte read at offset ofs above the frame base
  function automatic cpu_frame_t pop_merge(input cpu_frame_t f, input logic [3:0] ofs,
                                           input logic [7:0] d);
    cpu_frame_t r;
    r = f;
    case (ofs)
      4'd0:    r.ccr       = d;
      4'd1:    r.b         = d;
      4'd2:    r.a         = d;
      4'd3:    r.x[15:8]   = d;
      4'd4:    r.x[7:0]    = d;
      4'd5:    r.y[15:8]   = d;
      4'd6:    r.y[7:0]    = d;
      4'd7:    r.pc[15:8]  = d;
      default: r.pc[7:0]   = d;
    endcase
    return r;
  endfunction

  function automatic logic [15:0] push_addr(input logic [15:0] sp, input logic [3:0] idx);
    return sp - 16'(idx) - 16'd1;
  endfunction

  function automatic logic [15:0] pop_addr(input logic [15:0] sp, input logic [3:0] idx);
    return sp + 16'(idx);
  endfunction

  function automatic logic [15:0] vec_slot_addr(input logic [15:0] top, input logic nmi,
                                                input logic [7:0] idx);
    if (nmi) return top;
    return top - {7'd0, idx, 1'b0} - 16'd2;
  endfunction

  function automatic logic [7:0] set_masks(input logic [7:0] ccr, input logic nmi);
    logic [7:0] r;
    r = ccr;
    r[CCR_I_BIT] = 1'b1;
    if (nmi) r[CCR_X_BIT] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/intr_prio.sv
module intr_prio #(
  parameter int N_SRC = 8,
  parameter int SRC_W = 3
) (
  input  logic [N_SRC-1:0] irq_req,
  input  logic             nmi_req,
  input  logic             i_mask,
  input  logic             x_mask,
  output logic             take,
  output logic             take_nmi,
  output logic [SRC_W-1:0] pick
);
  logic any_irq;

  always_comb begin
    pick    = '0;
    any_irq = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (irq_req[i]) begin
        pick    = SRC_W'(i);
        any_irq = 1'b1;
      end
    end
  end

  assign take_nmi = nmi_req & ~x_mask;
  assign take     = take_nmi | (any_irq & ~i_mask);
endmodule

// File: rtl/intr_byte_ctr.sv
module intr_byte_ctr #(
  parameter int COUNT = 9,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         last
);
  localparam logic [W-1:0] LAST_V = W'(COUNT - 1);

  assign last = (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (step)   cnt <= last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/intr_stack_seq.sv
module intr_stack_seq
  import intr_seq_pkg::*;
#(
  parameter int          N_SRC   = 8,
  parameter logic [15:0] VEC_TOP = 16'hFFF4,
  localparam int         SRC_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_done,
  input  logic             rti_cmd,
  input  logic [N_SRC-1:0] irq_req,
  input  logic             nmi_req,
  input  logic [15:0]      pc_in,
  input  logic [15:0]      sp_in,
  input  logic [15:0]      x_in,
  input  logic [15:0]      y_in,
  input  logic [7:0]       a_in,
  input  logic [7:0]       b_in,
  input  logic [7:0]       ccr_in,
  output logic             flush,
  output logic             busy,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [15:0]      wr_addr,
  output logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [15:0]      rd_addr,
  input  logic [7:0]       rd_data,
  output logic             vec_valid,
  input  logic             vec_ready,
  output logic [15:0]      vec_addr,
  input  logic [15:0]      vec_data,
  output logic             reg_load,
  output logic [15:0]      pc_out,
  output logic [15:0]      sp_out,
  output logic [15:0]      x_out,
  output logic [15:0]      y_out,
  output logic [7:0]       a_out,
  output logic [7:0]       b_out,
  output logic [7:0]       ccr_out,
  output logic             svc_nmi,
  output logic [SRC_W-1:0] svc_src
);
  localparam int CNT_W = 4;

  seq_state_t       state;
  cpu_frame_t       frm;
  logic [15:0]      sp_r;
  logic [SRC_W-1:0] src_r;
  logic             nmi_r;

  // named internal events, observed by the checker
  logic             take, take_nmi;
  logic [SRC_W-1:0] pick;
  logic             accept_entry, start_return;
  logic             push_fire, push_last, pop_fire, pop_last, vec_fire;
  logic [CNT_W-1:0] cnt;
  logic             cnt_last, cnt_clr, cnt_step;

  intr_prio #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_prio (
    .irq_req  (irq_req),
    .nmi_req  (nmi_req),
    .i_mask   (ccr_in[CCR_I_BIT]),
    .x_mask   (ccr_in[CCR_X_BIT]),
    .take     (take),
    .take_nmi (take_nmi),
    .pick     (pick)
  );

  intr_byte_ctr #(.COUNT(FRAME_BYTES), .W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .step  (cnt_step),
    .cnt   (cnt),
    .last  (cnt_last)
  );

  assign start_return = (state == ST_IDLE) && rti_cmd;
  assign accept_entry = (state == ST_IDLE) && !rti_cmd && insn_done && take;

  assign wr_valid  = (state == ST_PUSH);
  assign rd_valid  = (state == ST_POP);
  assign vec_valid = (state == ST_VEC);
  assign flush     = (state == ST_CAPT);
  assign reg_load  = (state == ST_LOAD);
  assign busy      = (state != ST_IDLE);

  assign push_fire = wr_valid && wr_ready;
  assign pop_fire  = rd_valid && rd_ready;
  assign vec_fire  = vec_valid && vec_ready;
  assign push_last = cnt_last;
  assign pop_last  = cnt_last;

  assign cnt_clr  = (state == ST_IDLE) || (state == ST_CAPT);
  assign cnt_step = push_fire || pop_fire;

  assign wr_addr  = push_addr(sp_r, cnt);
  assign wr_data  = push_byte(frm, cnt);
  assign rd_addr  = pop_addr(sp_r, cnt);
  assign vec_addr = vec_slot_addr(VEC_TOP, nmi_r, 8'(src_r));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      frm   <= '0;
      sp_r  <= '0;
      src_r <= '0;
      nmi_r <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_return) begin
            sp_r  <= sp_in;
            state <= ST_POP;
          end else if (accept_entry) begin
            frm   <= '{pc: pc_in, y: y_in, x: x_in, a: a_in, b: b_in, ccr: ccr_in};
            sp_r  <= sp_in;
            nmi_r <= take_nmi;
            src_r <= pick;
            state <= ST_CAPT;
          end
        end
        ST_CAPT: state <= ST_PUSH;
        ST_PUSH: begin
          if (push_fire && push_last) begin
            frm.ccr <= set_masks(frm.ccr, nmi_r);
            state   <= ST_VEC;
          end
        end
        ST_VEC: begin
          if (vec_fire) begin
            frm.pc <= vec_data;
            sp_r   <= sp_r - 16'(FRAME_BYTES);
            state  <= ST_LOAD;
          end
        end
        ST_POP: begin
          if (pop_fire) begin
            frm <= pop_merge(frm, cnt, rd_data);
            if (pop_last) begin
              sp_r  <= sp_r + 16'(FRAME_BYTES);
              state <= ST_LOAD;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pc_out  = frm.pc;
  assign sp_out  = sp_r;
  assign x_out   = frm.x;
  assign y_out   = frm.y;
  assign a_out   = frm.a;
  assign b_out   = frm.b;
  assign ccr_out = frm.ccr;
  assign svc_nmi = nmi_r;
  assign svc_src = src_r;

endmodule

// File: rtl/intr_stack_seq_chk.sv
module intr_stack_seq_chk
  import intr_seq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [15:0] wr_addr,
  input logic [7:0]  wr_data,
  input logic        rd_valid,
  input logic [15:0] rd_addr,
  input logic        vec_valid,
  input logic        vec_ready,
  input logic [15:0] vec_addr,
  input logic        flush,
  input logic        busy,
  input logic        reg_load,
  input logic [7:0]  ccr_out,
  input logic [15:0] sp_out,
  input logic        push_fire,
  input logic        push_last,
  input logic        pop_fire,
  input logic        pop_last
);

  assert_flush_then_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (wr_valid && !flush));

  assert_push_descends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && !push_last) |=> (wr_valid && wr_addr == $past(wr_addr) - 16'd1));

  always_comb begin
    if (rst_n) begin
      assert_one_port_R4: assert ($onehot0({wr_valid, rd_valid, vec_valid}));
    end
  end

  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_mask_after_ccr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && push_last) |=> ccr_out[CCR_I_BIT]);

  assert_vec_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr)));

  assert_pop_sp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && pop_last) |=> (reg_load && sp_out == $past(rd_addr) + 16'd1));

  assert_busy_until_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(reg_load));

endmodule

bind intr_stack_seq intr_stack_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_valid  (rd_valid),
  .rd_addr   (rd_addr),
  .vec_valid (vec_valid),
  .vec_ready (vec_ready),
  .vec_addr  (vec_addr),
  .flush     (flush),
  .busy      (busy),
  .reg_load  (reg_load),
  .ccr_out   (ccr_out),
  .sp_out    (sp_out),
  .push_fire (push_fire),
  .push_last (push_last),
  .pop_fire  (pop_fire),
  .pop_last  (pop_last)
);

// File: tb/intr_stack_seq_tb.sv
`timescale 1ns/1ps
module intr_stack_seq_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          insn_done = 0, rti_cmd = 0, nmi_req = 0;
  logic [N-1:0]  irq_req = '0;
  logic [15:0]   pc_in = 0, sp_in = 0, x_in = 0, y_in = 0;
  logic [7:0]    a_in = 0, b_in = 0, ccr_in = 0;
  logic          flush, busy, wr_valid, rd_valid, vec_valid, reg_load, svc_nmi;
  logic          wr_ready = 0, rd_ready = 0, vec_ready = 0;
  logic [15:0]   wr_addr, rd_addr, vec_addr, vec_data, pc_out, sp_out, x_out, y_out;
  logic [7:0]    wr_data, rd_data, a_out, b_out, ccr_out;
  logic [2:0]    svc_src;

  logic [7:0] mem [0:511];

  function automatic logic [15:0] vec_content(input logic [15:0] adr);
    return adr ^ 16'h5A3C;
  endfunction

  assign vec_data = vec_content(vec_addr);
  assign rd_data  = mem[rd_addr[8:0]];

  intr_stack_seq #(.N_SRC(N), .VEC_TOP(16'hFFF4)) u_dut (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .rti_cmd(rti_cmd),
    .irq_req(irq_req), .nmi_req(nmi_req), .pc_in(pc_in), .sp_in(sp_in),
    .x_in(x_in), .y_in(y_in), .a_in(a_in), .b_in(b_in), .ccr_in(ccr_in),
    .flush(flush), .busy(busy), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_data(rd_data), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_addr(vec_addr), .vec_data(vec_data), .reg_load(reg_load), .pc_out(pc_out),
    .sp_out(sp_out), .x_out(x_out), .y_out(y_out), .a_out(a_out), .b_out(b_out),
    .ccr_out(ccr_out), .svc_nmi(svc_nmi), .svc_src(svc_src)
  );

  int n_tests = 0, n_fail = 0;
  int wn = 0, rn = 0, fn = 0, stall_err = 0;
  logic [15:0] wl_addr [0:15];
  logic [7:0]  wl_data [0:15];
  logic [7:0]  wl_ccr  [0:15];
  logic [15:0] rl_addr [0:15];
  logic        stall_pend = 0;
  logic [15:0] st_addr;
  logic [7:0]  st_data;

  // saved state of the last entry
  logic [15:0] o_pc, o_x, o_y, o_sp, e_sp_out;
  logic [7:0]  o_a, o_b, o_ccr;
  logic        accepted;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // handshake monitor
  initial forever begin
    @(posedge clk);
    if (rst_n) begin
      if (stall_pend && (!wr_valid || wr_addr !== st_addr || wr_data !== st_data))
        stall_err++;
      stall_pend = wr_valid && !wr_ready;
      st_addr = wr_addr;
      st_data = wr_data;
      if (wr_valid && wr_ready) begin
        mem[wr_addr[8:0]] = wr_data;
        if (wn < 16) begin
          wl_addr[wn] = wr_addr; wl_data[wn] = wr_data; wl_ccr[wn] = ccr_out;
        end
        wn++;
      end
      if (rd_valid && rd_ready) begin
        if (rn < 16) rl_addr[rn] = rd_addr;
        rn++;
      end
      if (flush) fn++;
    end
  end

  // random ready
  initial forever begin
    @(negedge clk);
    wr_ready  = ($urandom % 4) != 0;
    rd_ready  = ($urandom % 3) != 0;
    vec_ready = ($urandom % 2) != 0;
  end

  function automatic logic [15:0] exp_vec_addr(input logic nmi, input logic [N-1:0] irq);
    if (nmi) return 16'hFFF4;
    for (int i = 0; i < N; i++) if (irq[i]) return 16'hFFF4 - 16'(2 * (i + 1));
    return 16'h0000;
  endfunction

  function automatic logic [7:0] exp_byte(input int k);
    logic [7:0] t [0:8];
    t = '{o_pc[7:0], o_pc[15:8], o_y[7:0], o_y[15:8], o_x[7:0], o_x[15:8], o_a, o_b, o_ccr};
    return t[k];
  endfunction

  task automatic wait_load(input string req);
    int t = 0;
    while (!reg_load && t < 300) begin
      @(negedge clk);
      t++;
    end
    if (!reg_load) chk(req, "load strobe timeout", 0, 1);
  endtask

  task automatic entry(input logic [N-1:0] irq, input logic nmi, input logic [7:0] ccr,
                       input logic late);
    logic exp_nmi, exp_take;
    logic [15:0] va;
    int errs;
    @(negedge clk);
    o_pc = 16'($urandom); o_x = 16'($urandom); o_y = 16'($urandom);
    o_a = 8'($urandom); o_b = 8'($urandom); o_ccr = ccr;
    o_sp = 16'h0040 + 16'($urandom % 16'h01A0);
    irq_req = irq; nmi_req = nmi; ccr_in = ccr; pc_in = o_pc; x_in = o_x; y_in = o_y;
    a_in = o_a; b_in = o_b; sp_in = o_sp; insn_done = 1;
    wn = 0; fn = 0; rn = 0;
    exp_nmi  = nmi && !ccr[6];
    exp_take = exp_nmi || ((|irq) && !ccr[4]);
    va = exp_vec_addr(exp_nmi, irq);
    @(negedge clk);
    insn_done = 0;
    accepted = exp_take;
    if (!exp_take) begin
      repeat (4) @(negedge clk);
      chk("R1", "busy with request refused", 32'(busy), 0);
      chk("R1", "writes with request refused", wn, 0);
      irq_req = '0; nmi_req = 0;
      return;
    end
    chk("R10", "busy after accept", 32'(busy), 1);
    if (late) begin
      irq_req = '1; nmi_req = 1;   // R7: late requests must not alter the choice
    end
    wait_load("R8");
    chk("R3", "flush pulses", fn, 1);
    chk("R4", "write count", wn, 9);
    errs = 0;
    for (int k = 0; k < 9; k++) begin
      if (wl_addr[k] !== o_sp - 16'(k + 1)) errs++;
      if (wl_data[k] !== exp_byte(k)) errs++;
    end
    chk("R4", "frame mismatches", errs, 0);
    chk("R6", "ccr before mask", 32'(wl_ccr[8]), 32'(o_ccr));
    chk("R6", "ccr after mask", 32'(ccr_out), 32'(o_ccr | 8'h10 | (exp_nmi ? 8'h40 : 8'h00)));
    chk(late ? "R7" : "R2", "vector loaded", 32'(pc_out), 32'(vec_content(va)));
    chk("R8", "sp after entry", 32'(sp_out), 32'(o_sp - 16'd9));
    e_sp_out = sp_out;
    @(negedge clk);
    chk("R10", "busy after load", 32'(busy), 0);
    irq_req = '0; nmi_req = 0;
  endtask

  // return; expects the frame saved by the last entry
  task automatic do_return(input logic also_insn, input string req);
    int errs;
    @(negedge clk);
    sp_in = e_sp_out; rti_cmd = 1; insn_done = also_insn;
    if (also_insn) begin irq_req = 8'h01; ccr_in = 8'h00; end
    wn = 0; fn = 0; rn = 0;
    @(negedge clk);
    rti_cmd = 0; insn_done = 0; irq_req = '0;
    wait_load(req);
    chk(req, "read count", rn, 9);
    errs = 0;
    for (int k = 0; k < 9; k++) if (rl_addr[k] !== e_sp_out + 16'(k)) errs++;
    chk(req, "read address mismatches", errs, 0);
    chk(req, "flush on return", fn, 0);
    chk(req, "writes on return", wn, 0);
    chk("R9", "pc", 32'(pc_out), 32'(o_pc));
    chk("R9", "x", 32'(x_out), 32'(o_x));
    chk("R9", "y", 32'(y_out), 32'(o_y));
    chk("R9", "a/b", 32'({a_out, b_out}), 32'({o_a, o_b}));
    chk("R9", "ccr", 32'(ccr_out), 32'(o_ccr));
    chk("R9", "sp", 32'(sp_out), 32'(e_sp_out + 16'd9));
    @(negedge clk);
    chk("R10", "busy after return", 32'(busy), 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "reset outputs",
        32'({flush, busy, wr_valid, rd_valid, vec_valid, reg_load}), 0);

    // directed
    entry(8'b0010_0100, 0, 8'h00, 0);          // R2: line 2 wins
    do_return(0, "R9");
    entry(8'b1000_0000, 0, 8'h00, 1);          // R7: late change ignored
    do_return(0, "R9");
    entry(8'b0000_0011, 0, 8'h10, 0);          // R1: I set, refused
    entry(8'b0000_0011, 1, 8'h10, 0);          // R1: non-maskable passes I
    chk("R6", "serviced as non-maskable", 32'(svc_nmi), 1);
    do_return(0, "R9");
    entry(8'b0000_0000, 1, 8'h40, 0);          // R1: X set, refused
    entry(8'b0001_0000, 1, 8'h40, 0);          // R2: X set, maskable line 4
    chk("R2", "serviced line", 32'(svc_src), 4);
    do_return(1, "R11");                       // R11: return wins over entry

    // constrained random
    for (int it = 0; it < 40; it++) begin
      logic [N-1:0] irq;
      logic nmi;
      logic [7:0] ccr;
      irq = (($urandom % 4) == 0) ? '0 : N'($urandom);
      nmi = ($urandom % 3) == 0;
      ccr = 8'($urandom);
      entry(irq, nmi, ccr, ($urandom % 2) == 1);
      if (accepted) do_return(0, "R9");
    end

    chk("R5", "stall hold violations", stall_err, 0);
    finish_run();
  end
endmodule